// File: doc/BRIEF.md
# Strobed crosspoint control memory

This block is the control store behind a 4 by 4 crosspoint matrix that exists twice: a primary array and a mirrored primed array. It keeps one enable bit for each of the 16 X/Y pairs. A write presents a 4-bit address, one data bit and a strobe. The bit that the address selects takes the data value on the next rising clock edge. The enables come out as a 16-bit vector. They also drive a digital routing stage for each array: every Y output lane is the bitwise OR of the X input lanes that are enabled onto it.

The latches have no reset of their own. When the power-on reset input is released, a clearing sequencer takes over the write path. It writes zero to every address in turn, one address per clock, and then raises a ready flag. Until that flag is high, writes from the ports are locked out. The reset input restarts the sequencer only. The enables are cleared by the walk itself.

Top module: `xpt_ctrl_store`

## Requirements
- R1: Address bits 1:0 choose the X line. Bit 0 is the least significant, so values 0, 1, 2 and 3 select X1, X2, X3 and X4.
- R2: Address bits 3:2 choose the Y line. Bit 2 is the least significant, so values 0 to 3 select Y1 to Y4. The enable for pair (Xi, Yj), with i and j counted from zero, is `en_vec[4*j + i]`, which is the same as the address value.
- R3: When `strobe` is high at a rising clock edge and `clr_done` is high, the addressed enable takes the value of `din` (1 = on, 0 = off). The new value is visible after that edge.
- R4: A write changes only the addressed bit. The other 15 enables keep their values, and any number of enables may be on at the same time.
- R5: Each enable bit controls the same crosspoint in both arrays, so `y_sec` is formed from `x_sec` with exactly the same enables that form `y_pri` from `x_pri`.
- R6: After `rst_n` is released, the sequencer writes zero to addresses 0 through 15, one per clock. `clr_done` stays low for the first 15 rising edges and is high after the 16th edge. At that point `en_vec` is all zero, whatever the latches held before.
- R7: While `clr_done` is low, the `strobe`, `addr` and `din` ports have no effect on the enables.
- R8: When `strobe` is low at a rising edge, every enable holds its value.
- R9: Lane j of `y_pri` (bits 8*j+7 down to 8*j) is the bitwise OR of lanes i of `x_pri` for which pair (Xi, Yj) is enabled. It is zero when no pair on that Y line is enabled.
- R10: `clr_done` stays high until `rst_n` is asserted again. Asserting `rst_n` lowers it and starts a new clearing walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and sequencer steps on the rising edge |
| rst_n | input | 1 | Active-low power-on reset; restarts the clearing walk |
| addr | input | 4 | Crosspoint address: bits 1:0 select X, bits 3:2 select Y |
| strobe | input | 1 | Write strobe, sampled on the rising edge |
| din | input | 1 | Value written to the addressed enable |
| x_pri | input | 32 | Primary array X inputs, four 8-bit lanes, X1 in bits 7:0 |
| x_sec | input | 32 | Mirrored array X inputs, same lane layout |
| en_vec | output | 16 | Enable vector, bit 4*y + x |
| clr_done | output | 1 | High once the clearing walk has finished |
| y_pri | output | 32 | Primary array Y outputs, four 8-bit lanes, Y1 in bits 7:0 |
| y_sec | output | 32 | Mirrored array Y outputs, same lane layout |

## Verification
The hardest situation to reach is a write that arrives while the clearing walk is still running. It must be shown to have had no effect, even though the walk itself writes zeros. The bench handles this by holding the strobe high with data one on address 0 for the whole walk. Address 0 is cleared on the first step, so a write that leaked through would still show a one when the walk ends. The bench then repeats this after a reset in the middle of the run, when many enables are already set. The other hard case is several X lanes meeting on one Y line. Random write sequences build up many overlapping connections, and a directed case turns on all 16 pairs.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic {
    SEQ_CLEAR = 1'b0,
    SEQ_READY = 1'b1
  } seq_state_e;

  // Linear position of pair (xs, ys) in the enable vector.
  function automatic int unsigned pair_index(
    input int unsigned xs,
    input int unsigned ys,
    input int unsigned x_count
  );
    return ys * x_count + xs;
  endfunction

  // Lane base bit for lane k of width w.
  function automatic int unsigned lane_base(
    input int unsigned k,
    input int unsigned w
  );
    return k * w;
  endfunction

endpackage

// File: rtl/xpt_clear_seq.sv
module xpt_clear_seq #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] clr_addr
);
  import xpt_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  seq_state_e    state_q;
  logic [AW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_CLEAR;
      cnt_q   <= '0;
    end else if (state_q == SEQ_CLEAR) begin
      if (at_last) begin
        state_q <= SEQ_READY;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy     = (state_q == SEQ_CLEAR);
  assign done     = (state_q == SEQ_READY);
  assign clr_addr = cnt_q;

endmodule

// File: rtl/xpt_latch_bank.sv
module xpt_latch_bank #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_fire,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_bit,
  output logic [DEPTH-1:0] wr_hit,
  output logic [DEPTH-1:0] en_q
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign wr_hit[g] = wr_fire && (wr_addr == AW'(g));

    always_ff @(posedge clk) begin
      if (wr_hit[g]) begin
        en_q[g] <= wr_bit;
      end
    end
  end

endmodule

// File: rtl/xpt_router.sv
module xpt_router #(
  parameter int unsigned X_LINES = 4,
  parameter int unsigned Y_LINES = 4,
  parameter int unsigned LANE_W  = 8,
  localparam int unsigned NPAIR  = X_LINES * Y_LINES
) (
  input  logic [NPAIR-1:0]          en,
  input  logic [X_LINES*LANE_W-1:0] x_in,
  output logic [Y_LINES*LANE_W-1:0] y_out
);
  import xpt_pkg::*;

  for (genvar gj = 0; gj < Y_LINES; gj++) begin : g_yline
    logic [LANE_W-1:0] acc;

    always_comb begin
      acc = '0;
      for (int i = 0; i < X_LINES; i++) begin
        if (en[pair_index(i, gj, X_LINES)]) begin
          acc = acc | x_in[lane_base(i, LANE_W) +: LANE_W];
        end
      end
    end

    assign y_out[gj*LANE_W +: LANE_W] = acc;
  end

endmodule

// File: rtl/xpt_ctrl_store.sv
module xpt_ctrl_store #(
  parameter int unsigned X_LINES = 4,
  parameter int unsigned Y_LINES = 4,
  parameter int unsigned LANE_W  = 8,
  localparam int unsigned NPAIR  = X_LINES * Y_LINES,
  localparam int unsigned XW     = $clog2(X_LINES),
  localparam int unsigned YW     = $clog2(Y_LINES),
  localparam int unsigned AW     = XW + YW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             addr,
  input  logic                      strobe,
  input  logic                      din,
  input  logic [X_LINES*LANE_W-1:0] x_pri,
  input  logic [X_LINES*LANE_W-1:0] x_sec,
  output logic [NPAIR-1:0]          en_vec,
  output logic                      clr_done,
  output logic [Y_LINES*LANE_W-1:0] y_pri,
  output logic [Y_LINES*LANE_W-1:0] y_sec
);
  import xpt_pkg::*;

  logic          clr_busy;
  logic [AW-1:0] clr_addr;
  logic [XW-1:0] x_sel;
  logic [YW-1:0] y_sel;
  logic [AW-1:0] host_addr;
  logic          host_fire;
  logic          wr_fire;
  logic [AW-1:0] wr_addr;
  logic          wr_bit;
  logic [NPAIR-1:0] wr_hit;

  // X select in the low address bits, Y select above it.
  assign x_sel     = addr[XW-1:0];
  assign y_sel     = addr[AW-1:XW];
  assign host_addr = AW'(pair_index(int'(x_sel), int'(y_sel), X_LINES));
  assign host_fire = strobe && clr_done;

  // The clearing walk owns the write port until it has finished.
  assign wr_fire = clr_busy || host_fire;
  assign wr_addr = clr_busy ? clr_addr : host_addr;
  assign wr_bit  = clr_busy ? 1'b0 : din;

  xpt_clear_seq #(.DEPTH(NPAIR)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (clr_busy),
    .done     (clr_done),
    .clr_addr (clr_addr)
  );

  xpt_latch_bank #(.DEPTH(NPAIR)) bank_i (
    .clk     (clk),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .wr_hit  (wr_hit),
    .en_q    (en_vec)
  );

  xpt_router #(.X_LINES(X_LINES), .Y_LINES(Y_LINES), .LANE_W(LANE_W)) route_pri_i (
    .en    (en_vec),
    .x_in  (x_pri),
    .y_out (y_pri)
  );

  xpt_router #(.X_LINES(X_LINES), .Y_LINES(Y_LINES), .LANE_W(LANE_W)) route_sec_i (
    .en    (en_vec),
    .x_in  (x_sec),
    .y_out (y_sec)
  );

endmodule

// File: rtl/xpt_ctrl_store_chk.sv
module xpt_ctrl_store_chk #(
  parameter int unsigned X_LINES = 4,
  parameter int unsigned Y_LINES = 4,
  parameter int unsigned LANE_W  = 8,
  localparam int unsigned NPAIR  = X_LINES * Y_LINES,
  localparam int unsigned AW     = $clog2(NPAIR)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [AW-1:0]             addr,
  input logic                      strobe,
  input logic                      din,
  input logic [X_LINES*LANE_W-1:0] x_pri,
  input logic [X_LINES*LANE_W-1:0] x_sec,
  input logic [NPAIR-1:0]          en_vec,
  input logic                      clr_done,
  input logic [Y_LINES*LANE_W-1:0] y_pri,
  input logic [Y_LINES*LANE_W-1:0] y_sec,
  input logic [NPAIR-1:0]          wr_hit,
  input logic                      clr_busy
);

  // R3
  host_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && strobe) |=> (en_vec[$past(addr)] == $past(din)));

  // R4
  other_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && strobe) |=>
      ((en_vec & ~(NPAIR'(1) << $past(addr))) == ($past(en_vec) & ~(NPAIR'(1) << $past(addr)))));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !strobe) |=> $stable(en_vec));

  // R6
  walk_leaves_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_done) |-> (en_vec == '0));

  // R7
  locked_during_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> ($countones(wr_hit) == 1));

  // R10
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> clr_done);

  // R5
  mirror_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && (x_pri == x_sec)) |-> (y_pri == y_sec));

  // R9
  empty_routes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && (en_vec == '0)) |-> ((y_pri == '0) && (y_sec == '0)));

  // R4
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

bind xpt_ctrl_store xpt_ctrl_store_chk #(
  .X_LINES(X_LINES), .Y_LINES(Y_LINES), .LANE_W(LANE_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .strobe   (strobe),
  .din      (din),
  .x_pri    (x_pri),
  .x_sec    (x_sec),
  .en_vec   (en_vec),
  .clr_done (clr_done),
  .y_pri    (y_pri),
  .y_sec    (y_sec),
  .wr_hit   (wr_hit),
  .clr_busy (clr_busy)
);

// File: tb/xpt_ctrl_store_tb_top.sv
module xpt_ctrl_store_tb_top;

  localparam int XN = 4;
  localparam int YN = 4;
  localparam int LW = 8;
  localparam int NP = XN * YN;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    addr = '0;
  logic          strobe = 1'b0;
  logic          din = 1'b0;
  logic [31:0]   x_pri = '0;
  logic [31:0]   x_sec = '0;
  logic [15:0]   en_vec;
  logic          clr_done;
  logic [31:0]   y_pri;
  logic [31:0]   y_sec;

  int total = 0;
  int bad = 0;
  logic [15:0] model = '0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xpt_ctrl_store dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(strobe), .din(din),
    .x_pri(x_pri), .x_sec(x_sec), .en_vec(en_vec), .clr_done(clr_done),
    .y_pri(y_pri), .y_sec(y_sec)
  );

  // Expected routing: walk every pair and OR its X lane into its Y lane.
  function automatic logic [31:0] expect_route(input logic [15:0] en, input logic [31:0] xs);
    logic [31:0] r = '0;
    for (int k = 0; k < NP; k++) begin
      if (en[k]) r[(k / XN) * LW +: LW] = r[(k / XN) * LW +: LW] | xs[(k % XN) * LW +: LW];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Drive one write cycle at a falling edge and check after the next rising edge.
  task automatic put(input logic [3:0] a, input logic s, input logic d);
    addr = a; strobe = s; din = d;
    @(negedge clk);
    if (s) model[a] = d;
    strobe = 1'b0;
  endtask

  task automatic routes_check(input string tag);
    chk({tag, " R9 y_pri"}, y_pri, expect_route(model, x_pri));
    chk({tag, " R5 y_sec"}, y_sec, expect_route(model, x_sec));
  endtask

  // Reset, then keep an illegal write on address 0 during the whole walk.
  task automatic reset_and_walk(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({tag, " R10 done low in reset"}, 32'(clr_done), 32'd0);
    rst_n = 1'b1; addr = 4'd0; strobe = 1'b1; din = 1'b1;
    for (int c = 0; c < 15; c++) @(negedge clk);
    chk({tag, " R6 done low after 15 edges"}, 32'(clr_done), 32'd0);
    @(negedge clk);
    strobe = 1'b0;
    model = '0;
    chk({tag, " R6 done after 16 edges"}, 32'(clr_done), 32'd1);
    chk({tag, " R7 R6 enables cleared"}, 32'(en_vec), 32'd0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    reset_and_walk("first");

    // R1 R2: single writes land on bit 4*y + x
    for (int k = 0; k < NP; k++) begin
      put(4'(k), 1'b1, 1'b1);
      chk("R1 R2 decode on", 32'(en_vec), 32'(16'(1) << k));
      put(4'(k), 1'b1, 1'b0);
      chk("R3 decode off", 32'(en_vec), 32'd0);
    end

    // R1 R9: X2 onto Y3 is address 9 (x=1, y=2)
    x_pri = 32'h44332211; x_sec = 32'hDDCCBBAA;
    put(4'd9, 1'b1, 1'b1);
    chk("R1 R2 X2Y3 bit", 32'(en_vec), 32'h0200);
    chk("R9 X2 lane on Y3", y_pri, 32'h00220000);
    chk("R5 mirror X2' on Y3'", y_sec, 32'h00BB0000);

    // R9 multiple lanes onto one Y line, R4 other bits kept
    put(4'd8, 1'b1, 1'b1);
    put(4'd11, 1'b1, 1'b1);
    chk("R4 three bits on", 32'(en_vec), 32'h0B00);
    chk("R9 or of X1 X2 X4", y_pri, 32'h00770000);

    // R8: strobe low holds while address and data change
    addr = 4'd9; din = 1'b0; strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 hold with strobe low", 32'(en_vec), 32'h0B00);

    // Random sequence
    for (int n = 0; n < 600; n++) begin
      x_pri = $urandom; x_sec = $urandom;
      put(4'($urandom_range(15)), ($urandom_range(9) < 6), 1'($urandom));
      chk("R3 R4 R8 random enables", 32'(en_vec), 32'(model));
      routes_check("random");
      chk("R10 ready sticky", 32'(clr_done), 32'd1);
    end

    // All sixteen on
    for (int k = 0; k < NP; k++) put(4'(k), 1'b1, 1'b1);
    x_pri = 32'h80402010; x_sec = 32'h01020408;
    @(negedge clk);
    chk("R4 all on", 32'(en_vec), 32'hFFFF);
    chk("R9 full fan-in", y_pri, 32'hF0F0F0F0);
    chk("R5 full fan-in mirror", y_sec, 32'h0F0F0F0F);

    // Y line with nothing enabled drives zero
    for (int i = 0; i < XN; i++) put(4'(8 + i), 1'b1, 1'b0);
    chk("R9 empty Y3 zero", y_pri & 32'h00FF0000, 32'd0);

    // Reset mid-run with many bits set, illegal write held again
    reset_and_walk("second");
    x_pri = 32'hFFFFFFFF; x_sec = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R9 R6 nothing routed after walk", y_pri, 32'd0);
    routes_check("after walk");

    summary();
  end

endmodule